// File: doc/BRIEF.md
# Rewindable Synchronous FIFO

This block is a single-clock first-in first-out buffer that can replay stored data. A producer pushes words with a write enable. A consumer pops them with a read enable, qualified by a read select. A rewind request moves only the read side back to an anchor position, so the words from the anchor onward are delivered again. The write pointer, the stored words and the build-time read mode are left alone. The anchor is position zero after reset. Each mark request moves the anchor to the word the consumer would receive next.

Because a rewind may return to the anchor at any time, the block counts its occupancy from the anchor and not from the read pointer. Words that were already read but may still be replayed are never overwritten. Reads on their own therefore free no space; a mark does.

The block has two read modes, chosen by a parameter. In standard mode a pop loads the next word into an output register one cycle later, and the status flag is high while a word can be popped. In fall-through mode the head word is already on the output while the status flag is low, and a pop moves on to the next word.

Top module: `rewind_fifo`

## Requirements
- R1: While reset is held low and on the first cycle after, full is 0 and rd_data is 0. rd_flag is 0 in standard mode and 1 in fall-through mode, meaning no data.
- R2: A write with wr_en=1 and full=0 stores wr_data. full is 1 when 2**ADDR_W words lie between the anchor and the write position, and a write while full is ignored.
- R3: In standard mode (MODE=0), rd_flag=1 means a word can be popped. A pop (rd_en=1, rd_sel=1, rd_flag=1) presents the next word in write order on rd_data after the clock edge. A pop attempt while rd_flag=0 changes nothing.
- R4: While rd_sel=0, the rd_en, mark and rewind inputs have no effect.
- R5: In fall-through mode (MODE=1), rd_flag=0 means rd_data holds the head word, which stays put until it is popped. A pop moves rd_data on to the next word, or sets rd_flag to 1 when none is left.
- R6: A rewind (rewind=1, rd_sel=1) with no mark since reset makes the reader deliver again, starting from the first word written after reset.
- R7: A mark (mark=1, rd_sel=1) makes the anchor the word the consumer would receive next. In fall-through mode that is the word now on rd_data, if valid. A later rewind replays from that word.
- R8: In standard mode, rd_flag is 0 for exactly the one cycle after a rewind. After that it shows whether any words lie between the rewound read position and the write position.
- R9: In fall-through mode, rd_flag is 1 for the one cycle after a rewind. On the next cycle it becomes 0 with the anchored word on rd_data, if data is present.
- R10: A rewind leaves the write side untouched: a write in the same cycle is still stored, and the write position and full follow only writes and marks.
- R11: Pops do not lower full. Only a mark, which moves the anchor forward, frees space.
- R12: When a rewind and a mark or pop arrive in the same cycle, the rewind wins and the mark and pop are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| full | output | 1 | No room between the anchor and the write position |
| rd_en | input | 1 | Pop request |
| rd_sel | input | 1 | Read-side select; gates rd_en, mark and rewind |
| mark | input | 1 | Move the anchor to the next word due to the consumer |
| rewind | input | 1 | Move the read position back to the anchor |
| rd_data | output | DATA_W | Popped word (standard) or head word (fall-through) |
| rd_flag | output | 1 | Standard: 1 = a word can be popped. Fall-through: 0 = rd_data valid |

## Verification
The hardest cases to reach are a rewind that arrives while the buffer is full, in the same cycle as a write, a pop or a mark. Another is a mark taken just after the pointers wrap, so that it frees space that a write then uses at once. The bench drives both read modes from the same pseudo-random stream in several phases with different biases. Some phases only fill and drain, and never free space. Others mix frequent marks and rewinds with a read select that is often low. Integer position models for each mode predict every output on every cycle, so each collision is checked whenever it occurs.

// File: rtl/rwf_pkg.sv
// Shared definitions for the rewindable FIFO.
package rwf_pkg;
    // Read-side timing variant selected at build time.
    typedef enum logic {
        RD_STANDARD    = 1'b0,
        RD_FALLTHROUGH = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/rwf_store.sv
// Storage array, write position and full status.
// Assumes: the anchor never passes the write position and lies at most
// 2**AW words behind it; pointers carry one wrap bit.
module rwf_store #(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [AW:0]   anchor,
    input  logic [AW:0]   rd_addr,
    output logic [DW-1:0] rd_word,
    output logic [AW:0]   wp,
    output logic          full
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] fill;
    logic          wr_go;

    assign fill    = wp - anchor;
    assign full    = (fill == DEPTH_P);
    assign wr_go   = wr_en & ~full;
    assign rd_word = mem[rd_addr[AW-1:0]];

    // Store an accepted word at the write position.
    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem[wp[AW-1:0]] <= wr_data;
        end
    end

    // Advance the write position on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
        end else if (wr_go) begin
            wp <= wp + PW'(1);
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> (wp == $past(wp)));

    assert_fill_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill <= DEPTH_P));
endmodule

// File: rtl/rwf_anchor.sv
// Anchor register: the position a rewind returns to.
// Assumes: next_loc is the position of the word the consumer receives next.
module rwf_anchor #(
    parameter int AW = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mark_go,
    input  logic        rewind_go,
    input  logic [AW:0] next_loc,
    output logic [AW:0] anchor
);
    // Capture the next-delivery position on a mark; a rewind takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            anchor <= '0;
        end else if (mark_go && !rewind_go) begin
            anchor <= next_loc;
        end
    end

    assert_rewind_drops_mark_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_go |=> $stable(anchor));
endmodule

// File: rtl/rwf_reader.sv
// Read position, output register and status flag for either read mode.
// Assumes: rd_req is already qualified by the read select; rd_word is the
// storage word at rp.
module rwf_reader
    import rwf_pkg::*;
#(
    parameter int       DW   = 8,
    parameter int       AW   = 3,
    parameter rd_mode_e MODE = RD_STANDARD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          rewind_go,
    input  logic [AW:0]   anchor,
    input  logic [AW:0]   wp,
    input  logic [DW-1:0] rd_word,
    output logic [AW:0]   rp,
    output logic [AW:0]   next_loc,
    output logic [DW-1:0] rd_data,
    output logic          rd_flag
);
    localparam int PW = AW + 1;

    if (MODE == RD_STANDARD) begin : g_std
        logic blank;
        logic can_pop;
        logic pop;

        assign can_pop  = (wp != rp) & ~blank;
        assign pop      = rd_req & can_pop & ~rewind_go;
        assign rd_flag  = can_pop;
        assign next_loc = rp;

        // Rewind, or pop into the output register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rp      <= '0;
                blank   <= 1'b0;
                rd_data <= '0;
            end else if (rewind_go) begin
                rp    <= anchor;
                blank <= 1'b1;
            end else begin
                blank <= 1'b0;
                if (pop) begin
                    rd_data <= rd_word;
                    rp      <= rp + PW'(1);
                end
            end
        end

        assert_rewind_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
            rewind_go |=> !rd_flag);

        assert_rewind_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
            rewind_go |=> (rp == $past(anchor)));

        assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_req && !rd_flag && !rewind_go) |=> (rp == $past(rp)));
    end else begin : g_fwft
        logic out_vld;
        logic pop;
        logic load;

        assign pop      = rd_req & out_vld;
        assign load     = (wp != rp) & (~out_vld | pop) & ~rewind_go;
        assign rd_flag  = ~out_vld;
        assign next_loc = out_vld ? (rp - PW'(1)) : rp;

        // Rewind, refill the head register, or empty it on a pop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rp      <= '0;
                out_vld <= 1'b0;
                rd_data <= '0;
            end else if (rewind_go) begin
                rp      <= anchor;
                out_vld <= 1'b0;
            end else if (load) begin
                rd_data <= rd_word;
                rp      <= rp + PW'(1);
                out_vld <= 1'b1;
            end else if (pop) begin
                out_vld <= 1'b0;
            end
        end

        assert_rewind_notready_R9: assert property (@(posedge clk) disable iff (!rst_n)
            rewind_go |=> rd_flag);

        assert_head_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_flag && !rd_req && !rewind_go) |=> ($stable(rd_data) && !rd_flag));
    end
endmodule

// File: rtl/rewind_fifo.sv
// Single-clock FIFO with an anchor (mark) and read-side rewind.
// Assumes: all inputs are synchronous to clk; reset overrides the read select.
module rewind_fifo
    import rwf_pkg::*;
#(
    parameter int       DATA_W = 8,
    parameter int       ADDR_W = 3,
    parameter rd_mode_e MODE   = RD_STANDARD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    input  logic              rd_en,
    input  logic              rd_sel,
    input  logic              mark,
    input  logic              rewind,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag
);
    logic [ADDR_W:0]   wp;
    logic [ADDR_W:0]   rp;
    logic [ADDR_W:0]   anchor;
    logic [ADDR_W:0]   next_loc;
    logic [DATA_W-1:0] rd_word;
    logic              rd_req;
    logic              mark_go;
    logic              rewind_go;

    assign rd_req    = rd_en  & rd_sel;
    assign mark_go   = mark   & rd_sel;
    assign rewind_go = rewind & rd_sel;

    rwf_store #(.DW(DATA_W), .AW(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .anchor  (anchor),
        .rd_addr (rp),
        .rd_word (rd_word),
        .wp      (wp),
        .full    (full)
    );

    rwf_anchor #(.AW(ADDR_W)) u_anchor (
        .clk       (clk),
        .rst_n     (rst_n),
        .mark_go   (mark_go),
        .rewind_go (rewind_go),
        .next_loc  (next_loc),
        .anchor    (anchor)
    );

    rwf_reader #(.DW(DATA_W), .AW(ADDR_W), .MODE(MODE)) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rewind_go (rewind_go),
        .anchor    (anchor),
        .wp        (wp),
        .rd_word   (rd_word),
        .rp        (rp),
        .next_loc  (next_loc),
        .rd_data   (rd_data),
        .rd_flag   (rd_flag)
    );

    assert_rewind_keeps_wp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rewind_go && !wr_en) |=> $stable(wp));

    assert_rewind_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rewind_go && wr_en && !full) |=> (wp == $past(wp) + 1'b1));

    assert_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_sel |=> ($stable(rp) || rd_flag == (MODE == RD_STANDARD)));
endmodule

// File: tb/test_rewind_fifo.sv
`timescale 1ns/1ps
module test_rewind_fifo;
    import rwf_pkg::*;

    localparam int DW    = 8;
    localparam int AW    = 2;
    localparam int DEPTH = 1 << AW;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          wr_en = 0, rd_en = 0, rd_sel = 0, mark = 0, rewind = 0;
    logic [DW-1:0] wr_data = '0;
    logic          s_full, s_flag, f_full, f_flag;
    logic [DW-1:0] s_data, f_data;

    rewind_fifo #(.DATA_W(DW), .ADDR_W(AW), .MODE(RD_STANDARD)) i_rewind_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .full(s_full),
        .rd_en(rd_en), .rd_sel(rd_sel), .mark(mark), .rewind(rewind),
        .rd_data(s_data), .rd_flag(s_flag));

    rewind_fifo #(.DATA_W(DW), .ADDR_W(AW), .MODE(RD_FALLTHROUGH)) i_rewind_fifo_fwft (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .full(f_full),
        .rd_en(rd_en), .rd_sel(rd_sel), .mark(mark), .rewind(rewind),
        .rd_data(f_data), .rd_flag(f_flag));

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // Position models: absolute word indices since reset.
    int hs [4096];
    int hf [4096];
    int sw, sa, sr, sb, sd;
    int fw, fa, fr, fo, fd;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        sw = 0; sa = 0; sr = 0; sb = 0; sd = 0;
        fw = 0; fa = 0; fr = 0; fo = 0; fd = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; wr_en = 0; rd_en = 0; rd_sel = 1; mark = 1; rewind = 1;
        repeat (2) @(negedge clk);
        rst_n = 1; mark = 0; rewind = 0; rd_sel = 0;
        model_clear();
        chk("R1 standard flag", s_flag, 0);
        chk("R1 fall-through flag", f_flag, 1);
        chk("R1 standard full", s_full, 0);
        chk("R1 fall-through full", f_full, 0);
        chk("R1 standard data", s_data, 0);
        chk("R1 fall-through data", f_data, 0);
    endtask

    task automatic step(input bit we, input int wd, input bit re, input bit sel,
                        input bit mk, input bit rw);
        bit s_rw, s_can, s_fullx, s_rd, s_mk, f_rw, f_fullx, f_pop, f_mk, f_have;
        int s_na, f_na;
        wr_en = we; wr_data = wd[DW-1:0]; rd_en = re; rd_sel = sel; mark = mk; rewind = rw;
        // standard-mode expectation
        s_rw    = rw && sel;
        s_can   = (sw != sr) && (sb == 0);
        s_fullx = (sw - sa) == DEPTH;
        s_rd    = re && sel && s_can && !s_rw;
        s_mk    = mk && sel && !s_rw;
        s_na    = s_mk ? sr : sa;
        if (s_rw) begin sr = sa; sb = 1; end
        else begin
            sb = 0;
            if (s_rd) begin sd = hs[sr]; sr++; end
        end
        if (we && !s_fullx) begin hs[sw] = wd % 256; sw++; end
        sa = s_na;
        // fall-through expectation
        f_rw    = rw && sel;
        f_fullx = (fw - fa) == DEPTH;
        f_pop   = re && sel && (fo != 0);
        f_mk    = mk && sel && !f_rw;
        f_have  = (fw != fr);
        f_na    = f_mk ? ((fo != 0) ? fr - 1 : fr) : fa;
        if (f_rw) begin fr = fa; fo = 0; end
        else if (f_have && (fo == 0 || f_pop)) begin fd = hf[fr]; fr++; fo = 1; end
        else if (f_pop) fo = 0;
        if (we && !f_fullx) begin hf[fw] = wd % 256; fw++; end
        fa = f_na;
        @(negedge clk);
        chk("R3 R4 R8 R12 standard flag", s_flag, ((sw != sr) && sb == 0) ? 1 : 0);
        chk("R2 R10 R11 standard full", s_full, ((sw - sa) == DEPTH) ? 1 : 0);
        chk("R3 R4 R6 R7 R12 standard data", s_data, sd);
        chk("R5 R9 fall-through flag", f_flag, (fo != 0) ? 0 : 1);
        chk("R2 R10 R11 fall-through full", f_full, ((fw - fa) == DEPTH) ? 1 : 0);
        chk("R5 R6 R7 R12 fall-through data", f_data, fd);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    int wr_pct [6] = '{90, 50, 30, 70, 50, 95};
    int rd_pct [6] = '{10, 50, 80, 60, 90, 40};
    int sl_pct [6] = '{100, 90, 70, 100, 80, 50};
    int mk_pct [6] = '{0, 5, 10, 2, 20, 3};
    int rw_pct [6] = '{0, 3, 5, 10, 2, 8};

    initial begin
        @(negedge clk);
        for (int ph = 0; ph < 6; ph++) begin
            do_reset();
            for (int c = 0; c < 2000; c++) begin
                step($urandom_range(99) < wr_pct[ph], int'($urandom_range(255)),
                     $urandom_range(99) < rd_pct[ph], $urandom_range(99) < sl_pct[ph],
                     $urandom_range(99) < mk_pct[ph], $urandom_range(99) < rw_pct[ph]);
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule